// File: doc/BRIEF.md
# Two-Level Eight-Channel DMA Controller

The block moves data between peripherals and memory on behalf of up to seven requesters. It is organised as two four-channel register units. The upper unit holds channels 4 to 7, and its channel 4 is an internal link that stands for every request of the lower unit. The lower unit holds channels 0 to 3, which move bytes. Channels 5 to 7 move 16-bit words. Each channel keeps a base and a current address, a base and a current count, a mode and a mask bit. Each channel also has a terminal-count status bit.

A peripheral raises its request line. The block then picks the winning channel by fixed priority and raises a bus request. When the bus grant returns, it runs one transfer per cycle. In each transfer cycle it drives the acknowledge of the chosen channel, the bus address, the memory read or write strobe, and a terminal-count flag on the last transfer. A channel can run in single, block or demand mode. A clock-enable output for the transfer engine is high only in transfer cycles.

Registers are written through a simple write port, which carries a selector, a global channel number and a data word. Mask and status bits are visible as outputs.

Top module: `dma_cascade_ctrl`

## Requirements
- R1: After reset all eight mask bits are 1, all status bits are 0, and `hrq_o`, `dack_o`, `tc_o` and `eng_clk_en_o` are low.
- R2: A write with selector 6 (master reset) sets all eight mask bits, whatever the channel field holds.
- R3: A request is eligible when its mask bit is 0. Channels 0–3 are eligible only while the mask bit of channel 4 is also 0, and they then win over channels 5–7. Within a group the lowest channel number wins. `dreq_i[4]` is ignored, and `dack_o[4]` never rises.
- R4: `hrq_o` rises in the cycle after an eligible request appears. The first acknowledge appears in the cycle after `hlda_i` is seen high. At most one `dack_o` bit is high, and only while `hlda_i` and `hrq_o` are high.
- R5: During a transfer, a byte channel drives `addr_o` = {0, current address}. A word channel drives {current address, 0}. The address then steps by +1, or by −1 when mode bit 3 is set.
- R6: Each transfer decrements the current count. A transfer made at count 0 asserts `tc_o` and sets the channel's status bit. It also sets the mask bit, unless mode bit 2 (auto-initialise) is set. With auto-initialise, base address and base count are reloaded instead. A write with selector 7 clears the status bits of the unit that holds the channel.
- R7: Single mode (mode bits [5:4] = 01) makes one transfer per grant and then drops `hrq_o`.
- R8: Block mode (10) keeps transferring without regard to the request line until terminal count.
- R9: Demand mode (00) keeps transferring while the request is held. It stops after the cycle in which the request is seen low, or at terminal count.
- R10: `eng_clk_en_o` is high in exactly the cycles that carry an acknowledge.
- R11: A mode write is ignored when its type bits [1:0] are 00 (verify) or 11, or when its mode bits are 11 (cascade). A write with selector 5 (software request) has no effect.
- R12: Type 10 drives `mem_rd_o` during each transfer and type 01 drives `mem_wr_o`. Selectors are 0 address, 1 count, 3 set mask, 4 clear mask. Selector 2 writes the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector |
| cfg_chan | input | 3 | Global channel number for the write |
| cfg_wdata | input | DATA_W | Write data |
| dreq_i | input | 8 | Request lines per channel (bit 4 unused) |
| hlda_i | input | 1 | Bus grant |
| hrq_o | output | 1 | Bus request |
| dack_o | output | 8 | Acknowledge per channel |
| addr_o | output | ADDR_W+1 | Transfer address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| tc_o | output | 1 | Terminal count on this transfer |
| eng_clk_en_o | output | 1 | Transfer-engine clock enable |
| mask_o | output | 8 | Mask bits |
| tc_status_o | output | 8 | Terminal-count status bits |

## Verification
Terminal count and the fall of a demand request can land on the same transfer. In that cycle the burst has two reasons to end, and the mask update must still happen once. The bench provokes this with a demand burst whose request drop is timed to the very transfer that carries `tc_o`, as well as through random demand lengths. It judges the result by the exact number of acknowledges, `tc_o` on the last one only, and the mask and status outputs that follow. Priority between the lower group and the word channels is provoked by raising both requests in the same cycle, with the link channel masked and then unmasked.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int NCH_UNIT = 4;
  localparam int NUNITS   = 2;
  localparam int NCH      = NCH_UNIT * NUNITS;
  localparam int CH_W     = $clog2(NCH);
  localparam int LCH_W    = $clog2(NCH_UNIT);
  localparam int LINK_CH  = NCH_UNIT;
  localparam int MODE_W   = 6;

  typedef enum logic [2:0] {
    SEL_ADDR  = 3'd0,
    SEL_COUNT = 3'd1,
    SEL_MODE  = 3'd2,
    SEL_MSET  = 3'd3,
    SEL_MCLR  = 3'd4,
    SEL_SWREQ = 3'd5,
    SEL_MRST  = 3'd6,
    SEL_STCLR = 3'd7
  } cfg_sel_e;

  typedef enum logic [1:0] {
    XT_VERIFY = 2'b00, XT_WRITE = 2'b01, XT_READ = 2'b10, XT_RSVD = 2'b11
  } xfer_type_e;

  typedef enum logic [1:0] {
    XM_DEMAND = 2'b00, XM_SINGLE = 2'b01, XM_BLOCK = 2'b10, XM_CASCADE = 2'b11
  } xfer_mode_e;

  typedef struct packed {
    xfer_mode_e mode;
    logic       dec;
    logic       autoinit;
    xfer_type_e xtype;
  } chan_mode_t;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER, S_REL} eng_state_e;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] ch;
  } pick_t;

  // accepted only for real transfers in a supported mode
  function automatic logic mode_ok(input logic [MODE_W-1:0] w);
    chan_mode_t m;
    m = chan_mode_t'(w);
    return ((m.xtype == XT_WRITE) || (m.xtype == XT_READ)) && (m.mode != XM_CASCADE);
  endfunction

  // fixed priority, lower group seen through the link channel
  function automatic pick_t arbitrate(input logic [NCH-1:0] dreq, input logic [NCH-1:0] mask);
    pick_t p;
    logic [NCH-1:0] el;
    p  = '0;
    el = dreq & ~mask;
    el[LINK_CH] = 1'b0;
    if (!mask[LINK_CH] && (|el[NCH_UNIT-1:0])) begin
      p.hit = 1'b1;
      for (int i = NCH_UNIT - 1; i >= 0; i--)
        if (el[i]) p.ch = CH_W'(i);
    end else begin
      for (int i = NCH - 1; i > LINK_CH; i--)
        if (el[i]) begin
          p.ch  = CH_W'(i);
          p.hit = 1'b1;
        end
    end
    return p;
  endfunction

  function automatic logic burst_done(input xfer_mode_e m, input logic cnt_zero,
                                      input logic dreq_held);
    case (m)
      XM_SINGLE: return 1'b1;
      XM_BLOCK:  return cnt_zero;
      default:   return cnt_zero || !dreq_held;
    endcase
  endfunction
endpackage

// File: rtl/dma_unit_regs.sv
module dma_unit_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic                             cfg_hit,
  input  logic [2:0]                       cfg_sel,
  input  logic [LCH_W-1:0]                 cfg_lch,
  input  logic [DATA_W-1:0]                cfg_wdata,
  input  logic                             master_rst,
  input  logic                             step_en,
  input  logic                             step_hit,
  input  logic [LCH_W-1:0]                 step_lch,
  output logic [NCH_UNIT-1:0][ADDR_W-1:0]  cur_addr,
  output logic [NCH_UNIT-1:0][CNT_W-1:0]   cur_cnt,
  output chan_mode_t [NCH_UNIT-1:0]        mode,
  output logic [NCH_UNIT-1:0]              mask,
  output logic [NCH_UNIT-1:0]              tc_stat
);
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a, input logic dec);
    return dec ? (a - ADDR_W'(1)) : (a + ADDR_W'(1));
  endfunction

  logic stat_clr;
  assign stat_clr = cfg_we && cfg_hit && (cfg_sel == SEL_STCLR);

  for (genvar c = 0; c < NCH_UNIT; c++) begin : g_ch
    logic              wr_me, stp, at_tc;
    logic [ADDR_W-1:0] base_a, ca_q;
    logic [CNT_W-1:0]  base_c, cc_q;
    chan_mode_t        md_q;
    logic              mk_q, st_q;

    assign wr_me = cfg_we && cfg_hit && (cfg_lch == LCH_W'(c));
    assign stp   = step_en && step_hit && (step_lch == LCH_W'(c));
    assign at_tc = (cc_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_a <= '0;
        base_c <= '0;
        ca_q   <= '0;
        cc_q   <= '0;
        md_q   <= '0;
        mk_q   <= 1'b1;
        st_q   <= 1'b0;
      end else begin
        if (stp) begin
          if (at_tc && md_q.autoinit) begin
            ca_q <= base_a;
            cc_q <= base_c;
          end else begin
            ca_q <= addr_next(ca_q, md_q.dec);
            cc_q <= cc_q - CNT_W'(1);
          end
        end
        if (wr_me && (cfg_sel == SEL_ADDR)) begin
          base_a <= cfg_wdata[ADDR_W-1:0];
          ca_q   <= cfg_wdata[ADDR_W-1:0];
        end
        if (wr_me && (cfg_sel == SEL_COUNT)) begin
          base_c <= cfg_wdata[CNT_W-1:0];
          cc_q   <= cfg_wdata[CNT_W-1:0];
        end
        if (wr_me && (cfg_sel == SEL_MODE) && mode_ok(cfg_wdata[MODE_W-1:0]))
          md_q <= chan_mode_t'(cfg_wdata[MODE_W-1:0]);
        if (master_rst || (wr_me && (cfg_sel == SEL_MSET)) || (stp && at_tc && !md_q.autoinit))
          mk_q <= 1'b1;
        else if (wr_me && (cfg_sel == SEL_MCLR))
          mk_q <= 1'b0;
        if (stp && at_tc)
          st_q <= 1'b1;
        else if (stat_clr)
          st_q <= 1'b0;
      end
    end

    assign cur_addr[c] = ca_q;
    assign cur_cnt[c]  = cc_q;
    assign mode[c]     = md_q;
    assign mask[c]     = mk_q;
    assign tc_stat[c]  = st_q;
  end
endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_pkg::*;
(
  input  logic [NCH-1:0]  dreq,
  input  logic [NCH-1:0]  mask,
  output logic            req_any,
  output logic [CH_W-1:0] win_ch
);
  pick_t pick;
  assign pick    = arbitrate(dreq, mask);
  assign req_any = pick.hit;
  assign win_ch  = pick.ch;
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_any,
  input  logic [CH_W-1:0] win_ch,
  input  logic [NCH-1:0]  dreq,
  input  logic            hlda,
  input  xfer_mode_e      act_mode,
  input  logic            act_cnt_zero,
  output logic            hrq,
  output logic            xfer_active,
  output logic [CH_W-1:0] act_ch
);
  eng_state_e state_q;
  logic       stop_now;

  assign stop_now = burst_done(act_mode, act_cnt_zero, dreq[act_ch]) || !hlda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      act_ch  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_any) state_q <= S_REQ;
        S_REQ: if (hlda) begin
          if (req_any) begin
            state_q <= S_XFER;
            act_ch  <= win_ch;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_XFER: if (stop_now) state_q <= S_REL;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign hrq         = (state_q == S_REQ) || (state_q == S_XFER);
  assign xfer_active = (state_q == S_XFER);
endmodule

// File: rtl/dma_cascade_ctrl.sv
module dma_cascade_ctrl
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [2:0]        cfg_chan,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [7:0]        dreq_i,
  input  logic              hlda_i,
  output logic              hrq_o,
  output logic [7:0]        dack_o,
  output logic [ADDR_W:0]   addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              tc_o,
  output logic              eng_clk_en_o,
  output logic [7:0]        mask_o,
  output logic [7:0]        tc_status_o
);
  localparam int BUS_W = ADDR_W + 1;

  function automatic logic [BUS_W-1:0] bus_addr(input logic [ADDR_W-1:0] a, input logic word);
    return word ? {a, 1'b0} : {1'b0, a};
  endfunction

  logic [NCH-1:0][ADDR_W-1:0] all_addr;
  logic [NCH-1:0][CNT_W-1:0]  all_cnt;
  chan_mode_t [NCH-1:0]       all_mode;
  logic [NCH-1:0]             all_mask, all_stat;

  logic            master_rst, req_any, xfer_active;
  logic [CH_W-1:0] win_ch, act_ch;
  chan_mode_t      act_mode;
  logic            act_cnt_zero;

  assign master_rst = cfg_we && (cfg_sel == SEL_MRST);

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    localparam int LO = u * NCH_UNIT;
    logic [NCH_UNIT-1:0][ADDR_W-1:0] u_addr;
    logic [NCH_UNIT-1:0][CNT_W-1:0]  u_cnt;
    chan_mode_t [NCH_UNIT-1:0]       u_mode;
    logic [NCH_UNIT-1:0]             u_mask, u_stat;

    dma_unit_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_hit    (cfg_chan[CH_W-1] == 1'(u)),
      .cfg_sel    (cfg_sel),
      .cfg_lch    (cfg_chan[LCH_W-1:0]),
      .cfg_wdata  (cfg_wdata),
      .master_rst (master_rst),
      .step_en    (xfer_active),
      .step_hit   (act_ch[CH_W-1] == 1'(u)),
      .step_lch   (act_ch[LCH_W-1:0]),
      .cur_addr   (u_addr),
      .cur_cnt    (u_cnt),
      .mode       (u_mode),
      .mask       (u_mask),
      .tc_stat    (u_stat)
    );

    assign all_addr[LO +: NCH_UNIT] = u_addr;
    assign all_cnt[LO +: NCH_UNIT]  = u_cnt;
    assign all_mode[LO +: NCH_UNIT] = u_mode;
    assign all_mask[LO +: NCH_UNIT] = u_mask;
    assign all_stat[LO +: NCH_UNIT] = u_stat;
  end

  dma_arb u_arb (
    .dreq    (dreq_i),
    .mask    (all_mask),
    .req_any (req_any),
    .win_ch  (win_ch)
  );

  assign act_mode     = all_mode[act_ch];
  assign act_cnt_zero = (all_cnt[act_ch] == '0);

  dma_xfer_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_any      (req_any),
    .win_ch       (win_ch),
    .dreq         (dreq_i),
    .hlda         (hlda_i),
    .act_mode     (act_mode.mode),
    .act_cnt_zero (act_cnt_zero),
    .hrq          (hrq_o),
    .xfer_active  (xfer_active),
    .act_ch       (act_ch)
  );

  assign dack_o       = xfer_active ? (NCH'(1) << act_ch) : '0;
  assign addr_o       = xfer_active ? bus_addr(all_addr[act_ch], act_ch[CH_W-1]) : '0;
  assign mem_rd_o     = xfer_active && (act_mode.xtype == XT_READ);
  assign mem_wr_o     = xfer_active && (act_mode.xtype == XT_WRITE);
  assign tc_o         = xfer_active && act_cnt_zero;
  assign eng_clk_en_o = xfer_active;
  assign mask_o       = all_mask;
  assign tc_status_o  = all_stat;
endmodule

// File: rtl/dma_cascade_chk.sv
module dma_cascade_chk
  import dma_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_sel,
  input logic       hlda_i,
  input logic       hrq_o,
  input logic [7:0] dack_o,
  input logic       tc_o,
  input logic       eng_clk_en_o,
  input logic [7:0] mask_o,
  input logic [7:0] tc_status_o
);
  assert_dack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_o));

  assert_dack_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack_o) |-> (hlda_i && hrq_o));

  assert_dack_after_hrq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dack_o) |-> $past(hrq_o));

  assert_no_link_dack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dack_o[LINK_CH]);

  assert_tc_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> (($past(dack_o) & tc_status_o) != '0));

  assert_mrst_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel == SEL_MRST)) |=> (mask_o == '1));

  assert_clken_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_clk_en_o |-> (hrq_o && hlda_i));
endmodule

bind dma_cascade_ctrl dma_cascade_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_sel      (cfg_sel),
  .hlda_i       (hlda_i),
  .hrq_o        (hrq_o),
  .dack_o       (dack_o),
  .tc_o         (tc_o),
  .eng_clk_en_o (eng_clk_en_o),
  .mask_o       (mask_o),
  .tc_status_o  (tc_status_o)
);

// File: tb/dma_cascade_ctrl_bench.sv
module dma_cascade_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel, cfg_chan;
  logic [15:0] cfg_wdata;
  logic [7:0]  dreq;
  logic        hlda;
  logic        hrq, mem_rd, mem_wr, tc, clken;
  logic [7:0]  dack, mask, tcst;
  logic [16:0] addr;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] m_ba[8], m_ca[8], m_bc[8], m_cc[8];
  logic [5:0]  m_md[8];
  logic [7:0]  m_mask, m_st;

  always #5 clk = ~clk;

  dma_cascade_ctrl u_dma_cascade_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_chan(cfg_chan),
    .cfg_wdata(cfg_wdata), .dreq_i(dreq), .hlda_i(hlda), .hrq_o(hrq), .dack_o(dack),
    .addr_o(addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .tc_o(tc), .eng_clk_en_o(clken),
    .mask_o(mask), .tc_status_o(tcst)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit b_mode_ok(input logic [5:0] w);
    return (w[1:0] inside {2'b01, 2'b10}) && (w[5:4] != 2'b11);
  endfunction

  function automatic int exp_len(input int ch, input int dem_n);
    int left;
    left = int'(m_cc[ch]) + 1;
    case (m_md[ch][5:4])
      2'b01:   return 1;
      2'b10:   return left;
      default: return (dem_n < left) ? dem_n : left;
    endcase
  endfunction

  function automatic logic [16:0] exp_addr(input int ch);
    return 17'(m_ca[ch]) * ((ch > 4) ? 17'd2 : 17'd1);
  endfunction

  task automatic mstep(input int ch);
    bit at_end;
    at_end = (m_cc[ch] == 16'd0);
    if (at_end) m_st[ch] = 1'b1;
    if (at_end && m_md[ch][2]) begin
      m_ca[ch] = m_ba[ch];
      m_cc[ch] = m_bc[ch];
    end else begin
      m_ca[ch] = m_md[ch][3] ? m_ca[ch] - 16'd1 : m_ca[ch] + 16'd1;
      m_cc[ch] = m_cc[ch] - 16'd1;
      if (at_end) m_mask[ch] = 1'b1;
    end
  endtask

  task automatic wr(input int sel, input int ch, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_chan = 3'(ch); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      0: begin m_ba[ch] = d; m_ca[ch] = d; end
      1: begin m_bc[ch] = d; m_cc[ch] = d; end
      2: if (b_mode_ok(d[5:0])) m_md[ch] = d[5:0];
      3: m_mask[ch] = 1'b1;
      4: m_mask[ch] = 1'b0;
      6: m_mask = 8'hFF;
      7: for (int i = 0; i < 8; i++) if ((i / 4) == (ch / 4)) m_st[i] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic burst(input int ch, input int dem_n, input string tag);
    int exp_n, n;
    bit dem;
    dem   = (m_md[ch][5:4] == 2'b00);
    exp_n = exp_len(ch, dem_n);
    n = 0;
    @(negedge clk); dreq[ch] = 1'b1;
    @(negedge clk);
    chk(hrq === 1'b1, "R4 hrq one cycle after request", 64'(hrq), 1);
    hlda = 1'b1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (k == 0) chk(dack != 0, "R4 dack one cycle after grant", 64'(dack), 64'(1 << ch));
      if (dack != 0) begin
        chk(dack == 8'(1 << ch), "R3 acknowledged channel", 64'(dack), 64'(1 << ch));
        chk(addr == exp_addr(ch), "R5 bus address", 64'(addr), 64'(exp_addr(ch)));
        chk(tc == (m_cc[ch] == 16'd0), "R6 terminal count flag", 64'(tc), 64'(m_cc[ch] == 16'd0));
        chk({mem_rd, mem_wr} == m_md[ch][1:0], "R12 strobes", 64'({mem_rd, mem_wr}), 64'(m_md[ch][1:0]));
        chk(clken == 1'b1, "R10 clock enable in transfer", 64'(clken), 1);
        mstep(ch);
        n++;
        if (dem && (n == dem_n)) dreq[ch] = 1'b0;
      end else begin
        chk(clken == 1'b0, "R10 clock enable idle", 64'(clken), 0);
      end
      if (!hrq) break;
    end
    hlda = 1'b0;
    dreq[ch] = 1'b0;
    chk(n == exp_n, tag, 64'(n), 64'(exp_n));
    chk(mask == m_mask, "R6 mask after burst", 64'(mask), 64'(m_mask));
    chk(tcst == m_st, "R6 status after burst", 64'(tcst), 64'(m_st));
  endtask

  task automatic grant_first(output logic [7:0] seen);
    seen = '0;
    for (int k = 0; k < 5 && !hrq; k++) @(negedge clk);
    hlda = 1'b1;
    @(negedge clk);
    seen = dack;
    for (int k = 0; k < 20 && hrq; k++) @(negedge clk);
    hlda = 1'b0;
  endtask

  task automatic quiet(input string req);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(hrq == 1'b0 && dack == 8'h00, req, 64'(hrq), 0);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] seen;
    void'($urandom(32'd2718));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_chan = '0; cfg_wdata = '0;
    dreq = '0; hlda = 1'b0;
    for (int i = 0; i < 8; i++) begin
      m_ba[i] = '0; m_ca[i] = '0; m_bc[i] = '0; m_cc[i] = '0; m_md[i] = '0;
    end
    m_mask = 8'hFF; m_st = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(mask == 8'hFF, "R1 masks", 64'(mask), 8'hFF);
    chk(tcst == 8'h00, "R1 status", 64'(tcst), 0);
    chk({hrq, dack, tc, clken} == '0, "R1 outputs idle", 64'({hrq, dack, tc, clken}), 0);

    // R2 master reset
    wr(4, 0, 0); wr(4, 5, 0);
    chk(mask == 8'hDE, "R2 setup unmask", 64'(mask), 8'hDE);
    wr(6, 3, 0);
    chk(mask == 8'hFF, "R2 master reset masks all", 64'(mask), 8'hFF);

    // R3 priority across the link channel
    wr(2, 1, 16'h0011); wr(1, 1, 16'd10);
    wr(2, 6, 16'h0011); wr(1, 6, 16'd10);
    wr(4, 1, 0); wr(4, 4, 0); wr(4, 6, 0);
    @(negedge clk); dreq[1] = 1'b1; dreq[6] = 1'b1;
    grant_first(seen); dreq[1] = 1'b0;
    chk(seen == 8'h02, "R3 lower group wins", 64'(seen), 8'h02);
    grant_first(seen); dreq[6] = 1'b0;
    chk(seen == 8'h40, "R3 word channel next", 64'(seen), 8'h40);
    wr(3, 4, 0);
    @(negedge clk); dreq[1] = 1'b1; dreq[6] = 1'b1;
    grant_first(seen); dreq[6] = 1'b0;
    chk(seen == 8'h40, "R3 masked link hides lower group", 64'(seen), 8'h40);
    quiet("R3 lower request blocked by link mask");
    dreq[1] = 1'b0;
    wr(4, 4, 0);
    dreq[4] = 1'b1;
    quiet("R3 link request line ignored");
    dreq[4] = 1'b0;

    // R11 ignored writes
    wr(6, 0, 0); wr(7, 0, 0); wr(7, 4, 0);
    wr(2, 2, 16'h0012); wr(0, 2, 16'h0100); wr(1, 2, 16'd3);
    wr(4, 2, 0); wr(4, 4, 0);
    wr(2, 2, 16'h0020);
    wr(2, 2, 16'h0031);
    wr(2, 2, 16'h0013);
    wr(5, 2, 0);
    quiet("R11 software request has no effect");
    burst(2, 1, "R11 mode unchanged by ignored writes");

    // R8 block on a word channel with decrement, count 2
    wr(2, 7, 16'h0029); wr(0, 7, 16'h8000); wr(1, 7, 16'd2);
    wr(4, 7, 0);
    burst(7, 1, "R8 block runs to terminal count");

    // R6 auto-initialise in demand mode
    wr(2, 5, 16'h0006); wr(0, 5, 16'h0010); wr(1, 5, 16'd1);
    wr(4, 5, 0);
    burst(5, 4, "R6 auto-initialise burst length");
    chk(mask[5] == 1'b0, "R6 auto-initialise keeps mask clear", 64'(mask[5]), 0);

    // R9 demand early drop, then drop on the terminal-count transfer
    wr(2, 0, 16'h0001); wr(0, 0, 16'h00F0); wr(1, 0, 16'd5);
    wr(4, 0, 0);
    burst(0, 2, "R9 demand stops on request drop");
    wr(1, 0, 16'd1);
    burst(0, 2, "R9 demand drop on terminal count");

    // R7 single mode
    wr(2, 3, 16'h0012); wr(0, 3, 16'hFFFF); wr(1, 3, 16'd4);
    wr(4, 3, 0);
    burst(3, 1, "R7 single makes one transfer");

    // random mix covering R5 R6 R7 R8 R9 R10 R12
    for (int it = 0; it < 40; it++) begin
      int r, ch, mdv;
      logic [5:0] w;
      r   = $urandom_range(0, 6);
      ch  = (r < 4) ? r : r + 1;
      mdv = $urandom_range(0, 2);
      w   = {2'(mdv), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'($urandom_range(1, 2))};
      if ($urandom_range(0, 3) == 0) wr(2, ch, 16'($urandom_range(0, 63)));
      wr(2, ch, 16'(w));
      wr(0, ch, 16'($urandom));
      wr(1, ch, 16'($urandom_range(0, 5)));
      wr(4, ch, 0); wr(4, 4, 0);
      if (mdv == 1)      burst(ch, 1, "R7 random single length");
      else if (mdv == 2) burst(ch, 1, "R8 random block length");
      else               burst(ch, $urandom_range(1, 4), "R9 random demand length");
    end

    finish_run();
  end
endmodule